// File: doc/BRIEF.md
# Inter-Core Mailbox Pair

This block links two processor ports through two independent 32-bit first-in first-out queues, one carrying words in each direction. A port pushes a word into its outgoing queue by writing its transmit register. It pops a word from its incoming queue by reading its receive register. Each port sees only the push side of one queue and the pop side of the other. Both ports run on one shared clock.

Each port has a 4-bit status word and an interrupt line. The status word reports whether the incoming queue holds data and whether the outgoing queue has room. It also holds two sticky error flags: one records a push attempted while the outgoing queue was full, and the other records a pop attempted while the incoming queue was empty. The interrupt is raised while the port has data waiting or either error flag is set, so software can sleep until a word arrives or a protocol mistake needs attention. Any write to the status register clears both sticky flags.

A pop returns the word at the head of the incoming queue in the same cycle that the read strobe is high. The queue advances at the next clock edge. Pushes, flag updates and status changes all take effect at the clock edge that follows the strobe.

Top module: `xcore_mailbox`

## Requirements
- R1: After reset both queues are empty. Each port's status reads 4'b0010: only bit 1, transmit-ready, is set. Both interrupts are low, and read data is zero.
- R2: Words written by port 0 are read by port 1 in the order they were written. Words written by port 1 are read by port 0 in the same way. The two directions are independent.
- R3: Each queue holds 8 words. Status bit 1 (transmit-ready) is 1 exactly when the port's outgoing queue holds fewer than 8 words.
- R4: A push to a full queue discards the word and leaves the queue contents unchanged. At the next edge it sets status bit 2, the sticky write-on-full flag.
- R5: A pop from an empty queue returns zero and leaves the queue unchanged. At the next edge it sets status bit 3, the sticky read-on-empty flag.
- R6: A status write clears bits 2 and 3 at the next edge. If a new error of the same kind occurs in that cycle, the flag for that error stays set.
- R7: A port's interrupt equals the OR of its status bits 0, 2 and 3.
- R8: A push and a pop accepted on the same queue in one cycle leave its occupancy unchanged.
- R9: Status bit 0 (receive-valid) is 1 exactly when the port's incoming queue is not empty.
- R10: A push and a pop in the same cycle on an empty queue behave as follows. The pop is refused: it returns zero and sets read-on-empty. The pushed word is kept.
- R11: A push and a pop in the same cycle on a full queue behave as follows. The pop is accepted. The push is refused and sets write-on-full, so the queue ends with 7 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 2 | Per-port transmit register write strobe |
| wr_data | input | 2x32 | Per-port word to push |
| rd_en | input | 2 | Per-port receive register read strobe |
| rd_data | output | 2x32 | Per-port popped word; zero when not reading or when the queue is empty |
| st_wr | input | 2 | Per-port status register write strobe; clears the sticky flags |
| status | output | 2x4 | Per-port status: bit 0 receive-valid, bit 1 transmit-ready, bit 2 write-on-full, bit 3 read-on-empty |
| irq | output | 2 | Per-port interrupt |

## Verification
The assertions run on every cycle. They check that occupancy never exceeds the depth. They check that an accepted push and pop together keep the count steady, and that a refused push leaves a full queue alone. They also check that an overflow attempt always sets its flag, that an empty read returns zero, and that a clear with no competing error empties the flags.

Only the bench's scenarios can show the rest. These are first-in first-out ordering across many fills and drains, and the exact contents left after refused pushes and pops. They also include how the two directions interact when both ports act in the same cycle. A model-driven sweep compares data, every status bit and both interrupts cycle by cycle.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
    localparam int XMB_PORTS = 2;
    localparam int ST_W      = 4;
    // status bit positions
    localparam int ST_RXV    = 0;
    localparam int ST_TXR    = 1;
    localparam int ST_WOF    = 2;
    localparam int ST_ROE    = 3;
endpackage

// File: rtl/xmb_fifo.sv
module xmb_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign head    = st_q.mem[st_q.rp];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R8
    fifo_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(st_q.cnt));

    // R4
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(st_q.wp)));
endmodule

// File: rtl/xmb_port_view.sv
module xmb_port_view
    import xmb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              st_wr,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic [DATA_W-1:0] rx_head,
    output logic [DATA_W-1:0] rd_data,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    typedef struct packed {
        logic wof;
        logic roe;
    } flag_t;

    flag_t fl_q, fl_d;
    logic  ovf_evt, unf_evt;

    assign ovf_evt = wr_en && tx_full;
    assign unf_evt = rd_en && rx_empty;

    always_comb begin
        fl_d     = fl_q;
        // a fresh error outranks a clear in the same cycle
        fl_d.wof = ovf_evt || (fl_q.wof && !st_wr);
        fl_d.roe = unf_evt || (fl_q.roe && !st_wr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_comb begin
        rd_data = (rd_en && !rx_empty) ? rx_head : '0;
        status         = '0;
        status[ST_RXV] = !rx_empty;
        status[ST_TXR] = !tx_full;
        status[ST_WOF] = fl_q.wof;
        status[ST_ROE] = fl_q.roe;
        irq = status[ST_RXV] | status[ST_WOF] | status[ST_ROE];
    end

    // R4
    wof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_full) |=> status[ST_WOF]);

    // R5
    roe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_empty) |-> (rd_data == '0));

    // R6
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !(wr_en && tx_full) && !(rd_en && rx_empty))
            |=> (!status[ST_WOF] && !status[ST_ROE]));
endmodule

// File: rtl/xcore_mailbox.sv
module xcore_mailbox
    import xmb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [XMB_PORTS-1:0]               wr_en,
    input  logic [XMB_PORTS-1:0][DATA_W-1:0]   wr_data,
    input  logic [XMB_PORTS-1:0]               rd_en,
    output logic [XMB_PORTS-1:0][DATA_W-1:0]   rd_data,
    input  logic [XMB_PORTS-1:0]               st_wr,
    output logic [XMB_PORTS-1:0][ST_W-1:0]     status,
    output logic [XMB_PORTS-1:0]               irq
);
    // queue k carries words from port k to port (1-k)
    logic [XMB_PORTS-1:0]             q_full, q_empty;
    logic [XMB_PORTS-1:0][DATA_W-1:0] q_head;

    for (genvar k = 0; k < XMB_PORTS; k++) begin : g_dir
        xmb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (wr_en[k]),
            .din   (wr_data[k]),
            .pop   (rd_en[XMB_PORTS-1-k]),
            .head  (q_head[k]),
            .full  (q_full[k]),
            .empty (q_empty[k])
        );

        xmb_port_view #(.DATA_W(DATA_W)) u_view (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[k]),
            .rd_en    (rd_en[k]),
            .st_wr    (st_wr[k]),
            .tx_full  (q_full[k]),
            .rx_empty (q_empty[XMB_PORTS-1-k]),
            .rx_head  (q_head[XMB_PORTS-1-k]),
            .rd_data  (rd_data[k]),
            .status   (status[k]),
            .irq      (irq[k])
        );
    end
endmodule

// File: tb/xcore_mailbox_tb.sv
`timescale 1ns/1ps
module xcore_mailbox_tb;
    localparam int DW = 32;
    localparam int DP = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       wr_en = '0, rd_en = '0, st_wr = '0;
    logic [1:0][31:0] wr_data = '0;
    logic [1:0][31:0] rd_data;
    logic [1:0][3:0]  status;
    logic [1:0]       irq;

    int nchk = 0, nfail = 0;

    logic [31:0] mq0[$];
    logic [31:0] mq1[$];
    logic [1:0]  wof_m = '0, roe_m = '0;

    always #4 clk = ~clk;

    xcore_mailbox #(.DATA_W(DW), .DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .st_wr(st_wr),
        .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sz(input int k);
        return (k == 0) ? mq0.size() : mq1.size();
    endfunction

    function automatic logic [31:0] front(input int k);
        if (sz(k) == 0) return '0;
        return (k == 0) ? mq0[0] : mq1[0];
    endfunction

    task automatic check_status();
        for (int p = 0; p < 2; p++) begin
            chk("R9 rx-valid", 32'(status[p][0]), 32'(sz(1-p) != 0));
            chk("R3 tx-ready", 32'(status[p][1]), 32'(sz(p) < DP));
            chk("R4 wof", 32'(status[p][2]), 32'(wof_m[p]));
            chk("R5 roe", 32'(status[p][3]), 32'(roe_m[p]));
            chk("R7 irq", 32'(irq[p]), 32'((sz(1-p) != 0) || wof_m[p] || roe_m[p]));
        end
    endtask

    task automatic cyc(input logic [1:0] w, input logic [31:0] d0, input logic [31:0] d1,
                       input logic [1:0] r, input logic [1:0] s);
        logic [1:0] fullv, emptyv;
        @(negedge clk);
        check_status();
        wr_en = w; wr_data[0] = d0; wr_data[1] = d1; rd_en = r; st_wr = s;
        #1;
        for (int p = 0; p < 2; p++) begin
            if (r[p]) chk((sz(1-p) == 0) ? "R5 empty read" : "R2 read data",
                          rd_data[p], front(1-p));
            else      chk("R2 idle data", rd_data[p], '0);
        end
        for (int k = 0; k < 2; k++) begin
            fullv[k]  = (sz(k) == DP);
            emptyv[k] = (sz(k) == 0);
        end
        if (r[1] && !emptyv[0]) void'(mq0.pop_front());
        if (r[0] && !emptyv[1]) void'(mq1.pop_front());
        if (w[0] && !fullv[0]) mq0.push_back(d0);
        if (w[1] && !fullv[1]) mq1.push_back(d1);
        for (int p = 0; p < 2; p++) begin
            wof_m[p] = (w[p] && fullv[p]) || (wof_m[p] && !s[p]);
            roe_m[p] = (r[p] && emptyv[1-p]) || (roe_m[p] && !s[p]);
        end
        @(posedge clk);
        #1;
        wr_en = '0; rd_en = '0; st_wr = '0;
    endtask

    task automatic drain(input int p, output int n);
        n = 0;
        while (status[p][0] && n < 20) begin
            cyc(2'b00, 0, 0, 2'(1 << p), 2'b00);
            n++;
        end
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int p = 0; p < 2; p++) begin
            chk("R1 status", 32'(status[p]), 32'h2);
            chk("R1 irq", 32'(irq[p]), 0);
            chk("R1 data", rd_data[p], 0);
        end

        // R2 both directions, independent order
        for (int i = 0; i < 3; i++) cyc(2'b01, 32'hA000 + i, 0, 2'b00, 2'b00);
        for (int i = 0; i < 2; i++) cyc(2'b10, 0, 32'hB000 + i, 2'b00, 2'b00);
        drain(1, n); chk("R2 count p1", n, 3);
        drain(0, n); chk("R2 count p0", n, 2);

        // R3 fill to depth
        for (int i = 0; i < DP; i++) cyc(2'b01, 32'hC000 + i, 0, 2'b00, 2'b00);
        chk("R3 not ready when full", 32'(status[0][1]), 0);
        chk("R9 peer valid", 32'(status[1][0]), 1);
        // R4 overflow
        cyc(2'b01, 32'hDEAD, 0, 2'b00, 2'b00);
        chk("R4 wof set", 32'(status[0][2]), 1);
        chk("R7 irq on wof", 32'(irq[0]), 1);
        // R11 push refused on full even with pop in same cycle
        cyc(2'b01, 32'hBEEF, 0, 2'b10, 2'b00);
        drain(1, n); chk("R11 left 7", n, 7);

        // R6 clear vs fresh error
        for (int i = 0; i < DP; i++) cyc(2'b01, 32'hD000 + i, 0, 2'b00, 2'b00);
        cyc(2'b01, 32'h1111, 0, 2'b00, 2'b01);
        chk("R6 error beats clear", 32'(status[0][2]), 1);
        cyc(2'b00, 0, 0, 2'b00, 2'b01);
        chk("R6 cleared wof", 32'(status[0][2]), 0);
        chk("R6 cleared roe", 32'(status[0][3]), 0);
        chk("R7 irq low", 32'(irq[0]), 0);
        drain(1, n); chk("R6 drain", n, 8);

        // R5 empty read
        cyc(2'b00, 0, 0, 2'b01, 2'b00);
        chk("R5 roe set", 32'(status[0][3]), 1);
        chk("R5 still empty", 32'(status[0][0]), 0);
        // R10 push and pop together on empty queue
        cyc(2'b01, 32'h5151, 0, 2'b10, 2'b00);
        chk("R10 roe set", 32'(status[1][3]), 1);
        chk("R10 word kept", 32'(status[1][0]), 1);
        drain(1, n); chk("R10 count", n, 1);
        cyc(2'b00, 0, 0, 2'b00, 2'b11);

        // R8 simultaneous push and pop
        for (int i = 0; i < 3; i++) cyc(2'b10, 0, 32'hE000 + i, 2'b00, 2'b00);
        cyc(2'b10, 0, 32'hE0FF, 2'b01, 2'b00);
        drain(0, n); chk("R8 count kept", n, 3);

        // sweep with phase-biased traffic
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] w, r, s;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case ((i / 150) % 3)
                0: begin w = lf[1:0] | lf[3:2]; r = lf[5:4] & lf[7:6]; end
                1: begin w = lf[1:0] & lf[3:2]; r = lf[5:4] | lf[7:6]; end
                default: begin w = lf[1:0]; r = lf[5:4]; end
            endcase
            s = (lf[11:8] == 4'h0) ? lf[13:12] : 2'b00;
            cyc(w, lf ^ 32'(i), ~lf + 32'(i), r, s);
        end
        @(negedge clk);
        check_status();

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule